// File: doc/BRIEF.md
# Palette-or-Direct Pixel Selector

This block produces one display pixel per clock from three inputs that describe the same screen position. The inputs are an 8-bit colour index, a 32-bit direct-colour word and a 32-bit per-pixel control word. The top byte of the control word decides the colour source for that pixel. One tag value selects true colour, which is taken from the low three bytes of the direct word. Every other tag sends the index through a 256-entry RGB colour table.

The colour table has a write port and can be reloaded while pixels stream through. Each pixel carries an output-order flag that packs the result as RGB or as BGR. The result leaves a two-stage pipeline together with a valid bit. A fetch engine upstream supplies the three planes in lockstep, because all planes use the same pixel address. The block does no memory fetch and no video timing.

Top module: `pix_colour_sel`

## Requirements
- R1: A pixel is direct colour exactly when inCtrl[31:24] equals 8'h03. Every other tag value selects the colour table. inCtrl[23:0] never affects the result.
- R2: In direct mode, inDirect[23:16] is blue, inDirect[15:8] is green and inDirect[7:0] is red. inDirect[31:24] is ignored.
- R3: In table mode the output is the entry addressed by inIndex. Each entry holds red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: When swapBgr is 0, outPixel is {red, green, blue} with red in bits 23:16. When swapBgr is 1, outPixel is {blue, green, red}. The flag is sampled in the same cycle as the pixel.
- R5: outValid rises two clock edges after inValid and follows it exactly, so back-to-back inputs give back-to-back outputs with no bubble.
- R6: outPixel holds its last value in every cycle in which no valid pixel completes.
- R7: A write with palWe high stores palRgb at palAddr on the clock edge. A pixel that reads the same entry at that edge sees the old contents (read-first).
- R8: Reset drives outValid and outPixel to zero. It also clears every table entry to black, except the highest entry (index 255), which becomes all ones (white).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Pixel inputs valid this cycle |
| inIndex | input | 8 | Colour table index |
| inDirect | input | 32 | Direct-colour word |
| inCtrl | input | 32 | Per-pixel control word, tag in bits 31:24 |
| swapBgr | input | 1 | 1 packs the output as BGR |
| palWe | input | 1 | Colour table write enable |
| palAddr | input | 8 | Colour table write address |
| palRgb | input | 24 | Colour table write data, {R,G,B} |
| outValid | output | 1 | Output pixel valid |
| outPixel | output | 24 | Packed output colour |

## Verification
The bench builds the block with its default parameters: an 8-bit index, 8-bit channels and tag value 8'h03. These values give the full 256-entry table. The reset value of the top entry, 255, can therefore be checked directly, and tags that differ from 8'h03 in a single nibble or bit can be tried. The default word widths also let the bench put unrelated data in the ignored byte of the direct word and in the low control bits, and show that none of it reaches the output.

// File: rtl/pix_sel_pkg.sv
package pix_sel_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic capture;   // stage 1 takes a new pixel
    logic emit;      // stage 2 produces an output pixel
  } pix_strobe_t;
endpackage

// File: rtl/pix_sel_ctrl.sv
module pix_sel_ctrl
  import pix_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output pix_strobe_t strobe,
  output logic        outValid
);
  logic stage1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  assign strobe.capture = inValid;
  assign strobe.emit    = stage1Valid;

  // Edges since reset, saturating at two, so the checks never look before reset.
  logic [1:0] ageCnt;
  always_ff @(posedge clk) begin
    if (!rstN) ageCnt <= 2'd0;
    else if (ageCnt != 2'd2) ageCnt <= ageCnt + 2'd1;
  end

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd2) |-> (outValid == $past(inValid, 2)));

  // R5
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd2 && $past(inValid) && $past(inValid, 2)) |-> (outValid && strobe.emit));
endmodule

// File: rtl/pix_sel_data.sv
module pix_sel_data
  import pix_sel_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int CHAN_W     = 8,
  parameter int DIRECT_TAG = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  pix_strobe_t         strobe,
  input  logic [IDX_W-1:0]    inIndex,
  input  logic [4*CHAN_W-1:0] inDirect,
  input  logic [CHAN_W-1:0]   ctrlTag,
  input  logic                swapBgr,
  input  logic                palWe,
  input  logic [IDX_W-1:0]    palAddr,
  input  logic [3*CHAN_W-1:0] palRgb,
  output logic [3*CHAN_W-1:0] outPixel
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PIX_W = 3 * CHAN_W;
  localparam logic [CHAN_W-1:0] TAG = CHAN_W'(DIRECT_TAG);

  logic [PIX_W-1:0] palMem [DEPTH];
  logic [PIX_W-1:0] palRd;
  logic [PIX_W-1:0] s1Direct;
  logic             s1IsDirect;
  logic             s1Swap;

  // Colour table: the reset sets every entry to black and the top entry to white.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        palMem[i] <= (i == DEPTH - 1) ? {PIX_W{1'b1}} : {PIX_W{1'b0}};
    end else if (palWe) begin
      palMem[palAddr] <= palRgb;
    end
  end

  // Stage 1: table read (old data on a same-edge write), align the side data.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      palRd      <= '0;
      s1Direct   <= '0;
      s1IsDirect <= 1'b0;
      s1Swap     <= 1'b0;
    end else if (strobe.capture) begin
      palRd      <= palMem[inIndex];
      s1Direct   <= inDirect[PIX_W-1:0];
      s1IsDirect <= (ctrlTag == TAG);
      s1Swap     <= swapBgr;
    end
  end

  // Channel extraction: direct words keep blue high and red low.
  logic [CHAN_W-1:0] chR, chG, chB;
  always_comb begin
    if (s1IsDirect) begin
      chB = s1Direct[3*CHAN_W-1:2*CHAN_W];
      chG = s1Direct[2*CHAN_W-1:CHAN_W];
      chR = s1Direct[CHAN_W-1:0];
    end else begin
      chR = palRd[3*CHAN_W-1:2*CHAN_W];
      chG = palRd[2*CHAN_W-1:CHAN_W];
      chB = palRd[CHAN_W-1:0];
    end
  end

  // Stage 2: pack and register.
  always_ff @(posedge clk) begin
    if (!rstN) outPixel <= '0;
    else if (strobe.emit) outPixel <= s1Swap ? {chB, chG, chR} : {chR, chG, chB};
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else armed <= 1'b1;
  end

  // R2
  direct_red_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strobe.emit && s1IsDirect && !s1Swap))
      |-> (outPixel[3*CHAN_W-1:2*CHAN_W] == $past(s1Direct[CHAN_W-1:0])));

  // R4
  direct_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strobe.emit && s1IsDirect && s1Swap))
      |-> (outPixel[3*CHAN_W-1:2*CHAN_W] == $past(s1Direct[3*CHAN_W-1:2*CHAN_W])));

  // R4
  table_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(strobe.emit && !s1IsDirect && s1Swap))
      |-> (outPixel[CHAN_W-1:0] == $past(palRd[3*CHAN_W-1:2*CHAN_W])));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(strobe.emit)) |-> $stable(outPixel));

  // R7
  table_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(palWe)) |-> (palMem[$past(palAddr)] == $past(palRgb)));
endmodule

// File: rtl/pix_colour_sel.sv
module pix_colour_sel
  import pix_sel_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int CHAN_W     = 8,
  parameter int DIRECT_TAG = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [IDX_W-1:0]    inIndex,
  input  logic [4*CHAN_W-1:0] inDirect,
  input  logic [4*CHAN_W-1:0] inCtrl,
  input  logic                swapBgr,
  input  logic                palWe,
  input  logic [IDX_W-1:0]    palAddr,
  input  logic [3*CHAN_W-1:0] palRgb,
  output logic                outValid,
  output logic [3*CHAN_W-1:0] outPixel
);
  pix_strobe_t strobe;

  // Only the tag byte of the control word matters.
  logic unusedCtrlBits;
  assign unusedCtrlBits = ^inCtrl[3*CHAN_W-1:0];

  pix_sel_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pix_sel_data #(
    .IDX_W      (IDX_W),
    .CHAN_W     (CHAN_W),
    .DIRECT_TAG (DIRECT_TAG)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inIndex  (inIndex),
    .inDirect (inDirect),
    .ctrlTag  (inCtrl[4*CHAN_W-1:3*CHAN_W]),
    .swapBgr  (swapBgr),
    .palWe    (palWe),
    .palAddr  (palAddr),
    .palRgb   (palRgb),
    .outPixel (outPixel)
  );
endmodule

// File: tb/test_pix_colour_sel.sv
module test_pix_colour_sel;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [7:0]  inIndex;
  logic [31:0] inDirect;
  logic [31:0] inCtrl;
  logic        swapBgr;
  logic        palWe;
  logic [7:0]  palAddr;
  logic [23:0] palRgb;
  logic        outValid;
  logic [23:0] outPixel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  pix_colour_sel i_pix_colour_sel (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIndex(inIndex),
    .inDirect(inDirect), .inCtrl(inCtrl), .swapBgr(swapBgr),
    .palWe(palWe), .palAddr(palAddr), .palRgb(palRgb),
    .outValid(outValid), .outPixel(outPixel)
  );

  // {ctrl[96:65], direct[64:33], index[32:25], swap[24], expected[23:0]}
  localparam int NV = 8;
  localparam logic [96:0] VECS [NV] = '{
    {32'h03000000, 32'hFF112233, 8'd0,   1'b0, 24'h332211},  // R1 R2 direct RGB
    {32'h03000000, 32'hFF112233, 8'd0,   1'b1, 24'h112233},  // R4 direct BGR
    {32'h02FFFFFF, 32'h00AABBCC, 8'd5,   1'b0, 24'h112233},  // R3 table
    {32'h00000000, 32'h00AABBCC, 8'd9,   1'b1, 24'hC0B0A0},  // R4 table BGR
    {32'h13000000, 32'h00445566, 8'd5,   1'b0, 24'h112233},  // R1 near tag
    {32'h03FFFFFF, 32'h00445566, 8'd9,   1'b0, 24'h665544},  // R1 low ctrl ignored
    {32'h83000000, 32'h00000000, 8'd255, 1'b0, 24'hFFFFFF},  // R8 top entry
    {32'h07000000, 32'h12345678, 8'd0,   1'b0, 24'h000000}   // R8 entry 0
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] c, input logic [31:0] d,
                       input logic [7:0] idx, input logic sw);
    inValid = v; inCtrl = c; inDirect = d; inIndex = idx; swapBgr = sw;
  endtask

  task automatic palWrite(input logic [7:0] a, input logic [23:0] rgb);
    palWe = 1'b1; palAddr = a; palRgb = rgb;
    @(negedge clk);
    palWe = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 24'h0, 24'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; palWe = 1'b0; palAddr = '0; palRgb = '0;
    drive(1'b0, '0, '0, '0, 1'b0);
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 outValid", {23'd0, outValid}, 24'h0);
    check("R8 outPixel", outPixel, 24'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 read-first: write entry 7 while reading it in the same cycle.
    palWe = 1'b1; palAddr = 8'd7; palRgb = 24'h010203;
    drive(1'b1, 32'h0, 32'h0, 8'd7, 1'b0);
    @(negedge clk);
    palWe = 1'b0;
    drive(1'b1, 32'h0, 32'h0, 8'd7, 1'b0);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 8'd0, 1'b0);
    check("R7 same-edge read old", outPixel, 24'h000000);
    check("R5 valid after 2", {23'd0, outValid}, 24'h1);
    @(negedge clk);
    check("R7 next read new", outPixel, 24'h010203);
    @(negedge clk);

    palWrite(8'd5, 24'h112233);
    palWrite(8'd9, 24'hA0B0C0);

    // Vector table, back to back.
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        check($sformatf("R1-vec%0d R2 R3 R4 pixel", i - 2), outPixel, VECS[i-2][23:0]);
        check("R5 no bubble", {23'd0, outValid}, 24'h1);
      end
      if (i < NV)
        drive(1'b1, VECS[i][96:65], VECS[i][64:33], VECS[i][32:25], VECS[i][24]);
      else
        drive(1'b0, 32'h03000000, 32'hDEADBEEF, 8'd9, 1'b1);
      @(negedge clk);
    end

    // R6 hold across a gap while inputs change.
    drive(1'b1, 32'h0, 32'h0, 8'd5, 1'b0);
    @(negedge clk);
    drive(1'b0, 32'h03000000, 32'h00FFEEDD, 8'd9, 1'b1);
    @(negedge clk);
    check("R6 gap lead pixel", outPixel, 24'h112233);
    @(negedge clk);
    check("R6 hold outValid low", {23'd0, outValid}, 24'h0);
    check("R6 hold value", outPixel, 24'h112233);
    @(negedge clk);
    check("R6 hold value later", outPixel, 24'h112233);

    // R8 reset restores the top entry.
    palWrite(8'd255, 24'h123456);
    drive(1'b1, 32'h0, 32'h0, 8'd255, 1'b0);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 8'd0, 1'b0);
    @(negedge clk);
    check("R3 rewritten top", outPixel, 24'h123456);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 reset pixel", outPixel, 24'h0);
    check("R8 reset valid", {23'd0, outValid}, 24'h0);
    rstN = 1'b1;
    drive(1'b1, 32'h0, 32'h0, 8'd255, 1'b0);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 8'd0, 1'b0);
    @(negedge clk);
    check("R8 top entry white", outPixel, 24'hFFFFFF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule